// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a shared on-chip scratchpad that a group of 16 parallel lanes reads together. Storage is split into 32 word-interleaved banks, each 32 bits wide. A word address selects its bank with its low bits and the row inside that bank with the remaining bits. The default geometry (256 rows per bank, 13-bit word address) gives 32 KiB.

Each lane can ask for up to two independently addressed 32-bit words per group. A bank can serve only one word per cycle. The arbiter therefore grants every word whose bank is free in the current cycle and holds the rest pending for the next cycle. It keeps doing this until the whole group is served. Word slots are numbered lane-major: slot = 2 × lane + word. For a 128-bit per-lane read, software issues two groups, one for each 64-bit half.

Read data comes back per slot with a one-cycle valid pulse. A per-lane done flag, a group-complete pulse and a count of the cycles the group took are also reported. While a group is in flight, `busy` stalls the next request. A single-word write port fills the memory while no group is in flight.

Top module: `sp_scratchpad`

## Requirements
- R1: Word address `a` lives in bank `a mod 32` at row `a / 32`. A read of `a` returns the last word written to `a`.
- R2: Each bank serves at most one word per cycle. Words that collide are replayed on later cycles until every enabled word of the group is served. A group whose 32 words all hit one bank takes 32 cycles.
- R3: Among pending words that want the same bank, the lowest slot index wins. This means a lower lane wins over a higher lane, and a lane's word 0 (slot 2l) wins over its word 1 (slot 2l+1).
- R4: A group in which each lane l reads words base+2l and base+2l+1 has no conflicts and takes 1 cycle.
- R5: A 128-bit unit-stride read has lane l reading words base+4l to base+4l+3, issued as two 64-bit-half groups. Each half takes 2 cycles, so the pair takes 4 cycles.
- R6: A request is accepted only in a cycle where `req_valid` is 1, `busy` is 0 and `req_en` has at least one bit set. A request presented while `busy` is high, or with no enabled word, is ignored and returns nothing.
- R7: `busy` rises in the cycle after acceptance. It stays high until the cycle after the last word is granted, and at least one word is granted in every busy cycle.
- R8: A word granted in a cycle returns in the next cycle. Its bit in `rd_valid` pulses and the data appears in slot `rd_data[slot]`.
- R9: `lane_done[l]` is 1 once every enabled word of lane l in the current group has returned. A lane with no enabled words is done from the cycle after acceptance. All flags are 0 after reset.
- R10: `group_done` pulses in the cycle the last word returns. From then on, `group_cycles` holds the number of grant cycles the group used.
- R11: While `busy` is 0, asserting `wr_en` stores `wr_data` at `wr_addr` at the clock edge, one word per cycle. A write presented while `busy` is 1 is dropped.
- R12: After reset, `busy`, `rd_valid`, `lane_done`, `group_done` and `group_cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A read group is presented |
| req_en | input | 32 | Word enables, bit = slot (2×lane+word) |
| req_addr | input | 32×13 | Word address per slot |
| wr_en | input | 1 | Write one word |
| wr_addr | input | 13 | Word address of the write |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Group in flight; new requests and writes are not taken |
| rd_valid | output | 32 | Per-slot return pulse |
| rd_data | output | 32×32 | Per-slot return data, qualified by rd_valid |
| lane_done | output | 16 | All enabled words of the lane have returned |
| group_done | output | 1 | Pulse in the cycle the last word returns |
| group_cycles | output | 6 | Grant cycles used by the last group |

## Verification
The bench keeps its own model of the replay schedule and checks the cycle each word should return in, which slot it lands in, and its data.

- **Priority:** three words collide on one bank, from two lanes and both words of one lane. A design with the wrong priority would return them in the wrong order. The same group shows one lane's done flag set while the other's is still clear.
- **Conflict cost:** a fully colliding 32-word group and the 128-bit stride pattern measure how many cycles conflicts cost. A design that served two words from one bank would report too few cycles. A design that lost a pending word would never finish.
- **Interference during busy:** a request and a write are both presented while busy. A design that let either through would return extra words, or would corrupt a word that is read back later.
- **Empty request:** a request with no enabled word is presented. A design that accepted it would raise busy.

// File: rtl/sp_pkg.sv
// Shared defaults of the banked scratchpad. Sizes are powers of two; the
// bank index is the low field of a word address and the row the high field.
package sp_pkg;
    localparam int SP_LANES = 16;   // lanes in one request group
    localparam int SP_BANKS = 32;   // interleaved banks
    localparam int SP_ROWS  = 256;  // entries per bank (32 KiB in total)
    localparam int SP_DW    = 32;   // bank word width
endpackage

// File: rtl/sp_bank.sv
// One scratchpad bank: a single array with one read and one write access.
// Assumes the parent never reads and writes it in the same cycle.
// Read data is registered and valid in the cycle after rd_en.
module sp_bank #(
    parameter int DW   = 32,
    parameter int ROWS = 256,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem [ROWS];
    logic [DW-1:0] rdata_q;

    // store a word from the write port
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
    end

    // register the addressed word on a read
    always_ff @(posedge clk) begin
        if (rd_en) rdata_q <= mem[rd_row];
    end

    assign rd_data = rdata_q;
endmodule

// File: rtl/sp_arbiter.sv
// Bank conflict arbiter, purely combinational. For each bank it picks the
// pending slot with the lowest index that maps to it. Slot index is
// 2*lane+word, so lower lanes win and word 0 beats word 1.
// Assumes BANKS is a power of two.
module sp_arbiter #(
    parameter int SLOTS = 32,
    parameter int BANKS = 32,
    parameter int ROWS  = 256,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = BW + RW,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]          pend,
    input  logic [SLOTS-1:0][AW-1:0]  addr,
    output logic [SLOTS-1:0]          grant,
    output logic [BANKS-1:0]          bank_re,
    output logic [BANKS-1:0][RW-1:0]  bank_row,
    output logic [BANKS-1:0][SW-1:0]  bank_src
);
    // per bank, the first pending slot in index order takes the bank
    always_comb begin
        bank_re  = '0;
        bank_row = '0;
        bank_src = '0;
        for (int b = 0; b < BANKS; b++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (!bank_re[b] && pend[s] && (addr[s][BW-1:0] == BW'(b))) begin
                    bank_re[b]  = 1'b1;
                    bank_row[b] = addr[s][AW-1:BW];
                    bank_src[b] = SW'(s);
                end
            end
        end
    end

    // a slot is granted when its bank chose it
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            grant[s] = pend[s] && bank_re[addr[s][BW-1:0]]
                       && (bank_src[addr[s][BW-1:0]] == SW'(s));
        end
    end
endmodule

// File: rtl/sp_return.sv
// Return router: remembers which slot each bank served and steers the
// registered bank data into that slot one cycle after the grant.
// Slot data is zero whenever the slot is not valid.
module sp_return #(
    parameter int SLOTS = 32,
    parameter int BANKS = 32,
    parameter int DW    = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BANKS-1:0]          bank_re,
    input  logic [BANKS-1:0][SW-1:0]  bank_src,
    input  logic [BANKS-1:0][DW-1:0]  bank_rdata,
    output logic [SLOTS-1:0]          slot_valid,
    output logic [SLOTS-1:0][DW-1:0]  slot_data
);
    logic [BANKS-1:0]         vld_q;
    logic [BANKS-1:0][SW-1:0] src_q;

    // track the bank-to-slot routing of the access now in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            src_q <= '0;
        end else begin
            vld_q <= bank_re;
            src_q <= bank_src;
        end
    end

    // steer each returning bank word into its slot
    always_comb begin
        slot_valid = '0;
        slot_data  = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (vld_q[b]) begin
                slot_valid[src_q[b]] = 1'b1;
                slot_data[src_q[b]]  = bank_rdata[b];
            end
        end
    end
endmodule

// File: rtl/sp_scratchpad.sv
// Banked scratchpad top. It accepts a group of per-lane two-word reads when
// idle, replays bank conflicts until every word is granted, and returns data
// per slot one cycle after the grant. The write port is taken only when idle.
// Assumes power-of-two bank and row counts.
module sp_scratchpad
    import sp_pkg::*;
#(
    parameter int LANES = SP_LANES,
    parameter int BANKS = SP_BANKS,
    parameter int ROWS  = SP_ROWS,
    parameter int DW    = SP_DW,
    localparam int SLOTS = 2 * LANES,
    localparam int BW    = $clog2(BANKS),
    localparam int RW    = $clog2(ROWS),
    localparam int AW    = BW + RW,
    localparam int SW    = $clog2(SLOTS),
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [SLOTS-1:0]          req_en,
    input  logic [SLOTS-1:0][AW-1:0]  req_addr,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic                      busy,
    output logic [SLOTS-1:0]          rd_valid,
    output logic [SLOTS-1:0][DW-1:0]  rd_data,
    output logic [LANES-1:0]          lane_done,
    output logic                      group_done,
    output logic [CW-1:0]             group_cycles
);
    logic [SLOTS-1:0]         pend_q;
    logic [SLOTS-1:0][AW-1:0] addr_q;
    logic [SLOTS-1:0]         en_q;
    logic [SLOTS-1:0]         got_q;
    logic                     armed_q;
    logic [CW-1:0]            cnt_q;
    logic                     done_q;
    logic                     accept;
    logic                     wr_ok;
    logic [SLOTS-1:0]         grant;
    logic [BANKS-1:0]         bank_re;
    logic [BANKS-1:0][RW-1:0] bank_row;
    logic [BANKS-1:0][SW-1:0] bank_src;
    logic [BANKS-1:0][DW-1:0] bank_rdata;

    assign busy   = |pend_q;
    assign accept = req_valid && !busy && (|req_en);
    assign wr_ok  = wr_en && !busy;

    // pending words: loaded on accept, cleared as they are granted
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (accept) pend_q <= req_en;
        else             pend_q <= pend_q & ~grant;
    end

    // capture addresses and enables of the accepted group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            en_q    <= '0;
            armed_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            en_q    <= req_en;
            armed_q <= 1'b1;
        end
    end

    // collect returned words for the per-lane done flags
    always_ff @(posedge clk) begin
        if (!rst_n)      got_q <= '0;
        else if (accept) got_q <= '0;
        else             got_q <= got_q | rd_valid;
    end

    // count grant cycles of the group
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (accept) cnt_q <= '0;
        else if (busy)   cnt_q <= cnt_q + CW'(1);
    end

    // completion pulse in the cycle the final grant returns
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= busy && ((pend_q & ~grant) == '0);
    end

    sp_arbiter #(.SLOTS(SLOTS), .BANKS(BANKS), .ROWS(ROWS)) u_arbiter (
        .pend     (pend_q),
        .addr     (addr_q),
        .grant    (grant),
        .bank_re  (bank_re),
        .bank_row (bank_row),
        .bank_src (bank_src)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_ok && (wr_addr[BW-1:0] == BW'(b));
        sp_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
            .clk     (clk),
            .rd_en   (bank_re[b]),
            .rd_row  (bank_row[b]),
            .rd_data (bank_rdata[b]),
            .wr_en   (bank_we),
            .wr_row  (wr_addr[AW-1:BW]),
            .wr_data (wr_data)
        );
    end

    sp_return #(.SLOTS(SLOTS), .BANKS(BANKS), .DW(DW)) u_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_re    (bank_re),
        .bank_src   (bank_src),
        .bank_rdata (bank_rdata),
        .slot_valid (rd_valid),
        .slot_data  (rd_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // lane is done when each enabled word has returned or returns now
        assign lane_done[l] = armed_q
            && (&(~en_q[2*l +: 2] | got_q[2*l +: 2] | rd_valid[2*l +: 2]));
    end

    assign group_done   = done_q;
    assign group_cycles = cnt_q;
endmodule

// File: rtl/sp_checker.sv
// Protocol and arbitration checks for sp_scratchpad, attached by bind.
// Observes the pending mask, captured addresses and grants of the top.
module sp_checker #(
    parameter int LANES = 16,
    parameter int BANKS = 32,
    parameter int ROWS  = 256,
    localparam int SLOTS = 2 * LANES,
    localparam int BW    = $clog2(BANKS),
    localparam int AW    = BW + $clog2(ROWS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [SLOTS-1:0]          req_en,
    input logic                      busy,
    input logic [SLOTS-1:0]          pend,
    input logic [SLOTS-1:0][AW-1:0]  addr,
    input logic [SLOTS-1:0]          grant,
    input logic [SLOTS-1:0]          rd_valid,
    input logic                      group_done
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
        logic [SLOTS-1:0] want;
        logic [SLOTS-1:0] got;
        // slots that want this bank and slots it was given to
        always_comb begin
            for (int s = 0; s < SLOTS; s++) begin
                want[s] = pend[s]  && (addr[s][BW-1:0] == BW'(b));
                got[s]  = grant[s] && (addr[s][BW-1:0] == BW'(b));
            end
        end

        assert_bank_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(got));

        assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            got == (want & (~want + SLOTS'(1))));
    end

    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (|req_en)) |=> busy);

    assert_progress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (|grant));

    assert_return_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(grant));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        group_done |-> (!busy && $past(busy)));
endmodule

bind sp_scratchpad sp_checker #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS)) u_sp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_en     (req_en),
    .busy       (busy),
    .pend       (pend_q),
    .addr       (addr_q),
    .grant      (grant),
    .rd_valid   (rd_valid),
    .group_done (group_done)
);

// File: tb/test_sp_scratchpad.sv
// Scoreboard bench: the driver computes the replay schedule from the
// requirements and queues expected returns; a monitor pops and compares.
module test_sp_scratchpad;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int SLOTS = 32;
    localparam int BANKS = 32;
    localparam int BW    = 5;
    localparam int AW    = 13;
    localparam int WORDS = 8192;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       req_valid = 1'b0;
    logic [SLOTS-1:0]           req_en = '0;
    logic [SLOTS-1:0][AW-1:0]   req_addr = '0;
    logic                       wr_en = 1'b0;
    logic [AW-1:0]              wr_addr = '0;
    logic [31:0]                wr_data = '0;
    logic                       busy;
    logic [SLOTS-1:0]           rd_valid;
    logic [SLOTS-1:0][31:0]     rd_data;
    logic [LANES-1:0]           lane_done;
    logic                       group_done;
    logic [5:0]                 group_cycles;

    sp_scratchpad i_sp_scratchpad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_en(req_en),
        .req_addr(req_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .lane_done(lane_done),
        .group_done(group_done), .group_cycles(group_cycles)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          slot;
        logic [31:0] data;
        int          pass;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] shadow [WORDS];
    logic [AW-1:0] ta [SLOTS];
    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int acc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every returning word must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (rd_valid[s]) begin
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected return", 64'(s), 64'hFFFF);
                    end else begin
                        exp_t it;
                        it = sb_q.pop_front();
                        chk(it.slot == s, "R3 return order slot", 64'(s), 64'(it.slot));
                        chk(rd_data[s] == it.data, "R1 read data", 64'(rd_data[s]), 64'(it.data));
                        chk(cyc == acc + it.pass + 1, "R8 return cycle", 64'(cyc - acc), 64'(it.pass + 1));
                    end
                end
            end
        end
    end

    function automatic logic [31:0] pat(input int a, input int salt);
        return (32'(a) * 32'h9E3779B1) + 32'(salt);
    endfunction

    task automatic load_all(input int salt);
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(a, salt);
            shadow[a] = pat(a, salt);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_word(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = d;
    endtask

    // expected cycles: -1 means take the count from the schedule model
    task automatic run_group(input logic [SLOTS-1:0] en, input string req, input int exp_cyc,
                             input bit interfere, output int np);
        logic [SLOTS-1:0] pend;
        logic [BANKS-1:0] used;
        int p;
        pend = en;
        p = 0;
        while (pend != '0) begin
            used = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (pend[s] && !used[ta[s][BW-1:0]]) begin
                    used[ta[s][BW-1:0]] = 1'b1;
                    pend[s] = 1'b0;
                    sb_q.push_back('{s, shadow[ta[s]], p});
                end
            end
            p++;
        end
        np = p;
        if (exp_cyc < 0) exp_cyc = p;
        @(negedge clk);
        req_valid = 1'b1;
        req_en = en;
        for (int s = 0; s < SLOTS; s++) req_addr[s] = ta[s];
        @(negedge clk);
        acc = cyc;
        if (interfere) begin
            req_en = '1;
            wr_en = 1'b1; wr_addr = AW'(300); wr_data = 32'hBAD0BAD0;
        end else begin
            req_valid = 1'b0;
        end
        chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
        if (interfere) begin
            @(negedge clk);
            req_valid = 1'b0; wr_en = 1'b0;
            if (group_done) chk(1'b0, "R10 done too early", 64'd1, 64'd0);
        end
        while (!group_done) @(negedge clk);
        chk(group_cycles == 6'(exp_cyc), {req, " group cycles"}, 64'(group_cycles), 64'(exp_cyc));
        chk(lane_done == '1, "R9 all lanes done", 64'(lane_done), 64'hFFFF);
        chk(busy == 1'b0, "R7 busy low at completion", 64'(busy), 64'd0);
        @(negedge clk);
        chk(sb_q.size() == 0, "R8 all words returned", 64'(sb_q.size()), 64'd0);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        int np;
        int np2;
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(busy == 0, "R12 busy", 64'(busy), 0);
        chk(rd_valid == '0, "R12 rd_valid", 64'(rd_valid), 0);
        chk(lane_done == '0, "R12 lane_done", 64'(lane_done), 0);
        chk(group_done == 0, "R12 group_done", 64'(group_done), 0);
        chk(group_cycles == 0, "R12 group_cycles", 64'(group_cycles), 0);
        rst_n = 1'b1;

        // R11: fill memory through the write port
        load_all(17);

        // R4: 64-bit unit stride, no conflicts
        for (int l = 0; l < LANES; l++) begin
            ta[2*l] = AW'(256 + 2*l); ta[2*l+1] = AW'(256 + 2*l + 1);
        end
        run_group('1, "R4", 1, 1'b0, np);

        // R5: 128-bit unit stride as two halves, 2 cycles each
        for (int l = 0; l < LANES; l++) begin
            ta[2*l] = AW'(512 + 4*l); ta[2*l+1] = AW'(512 + 4*l + 1);
        end
        run_group('1, "R5 first half", 2, 1'b0, np);
        for (int l = 0; l < LANES; l++) begin
            ta[2*l] = AW'(512 + 4*l + 2); ta[2*l+1] = AW'(512 + 4*l + 3);
        end
        run_group('1, "R5 second half", 2, 1'b0, np2);
        chk(np + np2 == 4, "R5 total cycles", 64'(np + np2), 64'd4);

        // R3 and R9: three words on bank 5, lane 0 finishes before lane 1
        for (int s = 0; s < SLOTS; s++) ta[s] = '0;
        ta[0] = AW'(5); ta[1] = AW'(69); ta[2] = AW'(37);
        fork
            run_group(32'h7, "R3", 3, 1'b0, np);
            begin
                repeat (4) @(negedge clk);
                chk(lane_done[1:0] == 2'b01, "R9 lane 0 done before lane 1", 64'(lane_done[1:0]), 64'd1);
            end
        join

        // R2: all 32 words on bank 7
        for (int s = 0; s < SLOTS; s++) ta[s] = AW'(7 + 32*s);
        run_group('1, "R2", 32, 1'b0, np);

        // R9 and R1: sparse enables, scattered addresses
        for (int s = 0; s < SLOTS; s++) ta[s] = AW'((s * 97 + 13) % WORDS);
        run_group(32'h0000_A0C2, "R9 sparse", -1, 1'b0, np);
        for (int s = 0; s < SLOTS; s++) ta[s] = AW'((s * 1061 + 40) % WORDS);
        run_group(32'hF00F_5A5A, "R1 scattered", -1, 1'b0, np);

        // R1: rewritten word is read back
        write_word(100, 32'hDEADBEEF);

        // R6 and R11: request and write presented while busy are dropped
        for (int s = 0; s < SLOTS; s++) ta[s] = '0;
        ta[0] = AW'(3); ta[1] = AW'(35); ta[2] = AW'(67); ta[3] = AW'(99);
        run_group(32'hF, "R6", 4, 1'b1, np);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R6 request during busy ignored", 64'(busy), 64'd0);

        ta[0] = AW'(300); ta[1] = AW'(100);
        run_group(32'h3, "R11 write during busy dropped", 1, 1'b0, np);

        // R6: empty request is not accepted
        @(negedge clk);
        req_valid = 1'b1; req_en = '0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b0, "R6 empty request", 64'(busy), 64'd0);
        repeat (2) @(negedge clk);
        chk(group_done == 1'b0, "R6 empty request no completion", 64'(group_done), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule